// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a bank of 32-bit control words for a system control unit, reached over a simple single-cycle register bus. Six of the words drive downstream lines directly: two reset-control words, two clock-stop words and two strap words. Each of these is exposed as an output port. Every one of the six owns a companion clear address one word above it. A write of ones there clears the matching bits of the word below. The companion holds no storage of its own.

The reset-control and clock-stop words accumulate bits: a write to their own address ORs the data in. The strap words take a plain overwrite at their own address. All other in-range words are ordinary read/write storage. An access whose word index lies beyond the implemented range changes nothing, and it raises a one-cycle error pulse. The bus data path may be wider than 32 bits. Only its low 32 bits take part.

Top module: `sc_alias_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two. The two low address bits are ignored, and each word is 32 bits.
- R2: The reset-control words (byte 0x40, 0x50) and clock-stop words (byte 0x80, 0x90) are set-type: a write makes new = old | data.
- R3: A write to a companion clear address (primary + 4) makes the primary word new = old & ~data. Zero bits in the data leave their bits unchanged.
- R4: Companion clear addresses hold no storage. A read of one returns zero, and a write to one alters no word other than its primary.
- R5: The strap words (byte 0x10, 0x18) are overwritten by a write to their own address. They are cleared bitwise through 0x14 and 0x1C.
- R6: Every other in-range word is plain storage: a write replaces it, and a read returns the last value written.
- R7: Only wr_data[31:0] is used. Upper bus bits have no effect on any word.
- R8: With NUM_REGS = 48, an access to word index 48 or above (byte 0xC0 and up) writes nothing and reads zero. It raises err for exactly the one cycle after the access.
- R9: A synchronous active-high reset loads these values: strap0 0x12345678, strap1 0x80000001, reset-control0 0x000000F0, reset-control1 0, clock-stop0 0xFFFF0000, clock-stop1 0x0000FFFF, and all plain words 0. The same reset clears rd_data and err.
- R10: rd_data takes the addressed value one cycle after rd_en. A write in the same cycle is not yet visible to that read. rd_data holds while rd_en is low.
- R11: The control-word output ports change only in the cycle after a write to their primary or companion address.
- R12: A set write followed by a clear write with the same mask returns a set-type word to its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BUS_W | Write data, low 32 bits used |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse after an out-of-range access |
| strap0_q | output | 32 | Strap word 0 |
| strap1_q | output | 32 | Strap word 1 |
| rstc0_q | output | 32 | Reset-control word 0 |
| rstc1_q | output | 32 | Reset-control word 1 |
| clkstop0_q | output | 32 | Clock-stop word 0 |
| clkstop1_q | output | 32 | Clock-stop word 1 |

## Verification
The set words are driven with masks that overlap their reset value and with masks that do not, which separates an OR from an overwrite. Clear masks are chosen with bits both inside and outside the stored value, and the companion address is then read back. This shows whether a clear hit the word below or the alias itself. Strap words receive a primary write followed by a clear, to confirm that the overwrite and clear paths differ. Writes with set upper bus bits, unaligned addresses, out-of-range indices and a read that coincides with a write pin down truncation, decoding, the error pulse and read ordering.

// File: rtl/sc_alias_pkg.sv
package sc_alias_pkg;
  localparam int DATA_W = 32;
  localparam int NCTL   = 6;

  // control slots: 0,1 strap; 2,3 reset control; 4,5 clock stop
  function automatic int ctl_prim_idx(input int k);
    case (k)
      0: return 4;
      1: return 6;
      2: return 16;
      3: return 20;
      4: return 32;
      5: return 36;
      default: return 0;
    endcase
  endfunction

  function automatic bit ctl_is_set(input int k);
    return (k >= 2);
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 48,
  localparam int IDX_W   = ADDR_W - 2,
  localparam int NCTL    = sc_alias_pkg::NCTL
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic [NCTL-1:0]   prim_hit,
  output logic [NCTL-1:0]   clr_hit
);
  logic [1:0] unused_lsb;
  assign unused_lsb = addr[1:0];
  assign idx        = addr[ADDR_W-1:2];
  assign in_range   = (int'(idx) < NUM_REGS);

  for (genvar k = 0; k < NCTL; k++) begin : g_slot
    localparam int PI = sc_alias_pkg::ctl_prim_idx(k);
    assign prim_hit[k] = in_range && (idx == IDX_W'(PI));
    assign clr_hit[k]  = in_range && (idx == IDX_W'(PI + 1));
  end
endmodule

// File: rtl/sc_ctl_word.sv
module sc_ctl_word #(
  parameter int                DATA_W    = 32,
  parameter bit                SET_TYPE  = 1'b1,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              prim_hit,
  input  logic              clr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                    q <= RESET_VAL;
    else if (wr_en && clr_hit)  q <= q & ~wdata;
    else if (wr_en && prim_hit) q <= SET_TYPE ? (q | wdata) : wdata;
  end

  // R2: a set write leaves every data one-bit set
  a_r2_set_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (SET_TYPE && wr_en && prim_hit) |=> ((q & $past(wdata)) == $past(wdata)));
  // R3: a clear write leaves every data one-bit cleared
  a_r3_clear_drops_ones: assert property (@(posedge clk) disable iff (rst)
    (wr_en && clr_hit) |=> ((q & $past(wdata)) == '0));
  // R5: a strap primary write overwrites
  a_r5_strap_overwrite: assert property (@(posedge clk) disable iff (rst)
    (!SET_TYPE && wr_en && prim_hit && !clr_hit) |=> (q == $past(wdata)));
  // R11: no hit, no change
  a_r11_hold_without_hit: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (prim_hit || clr_hit)) |=> $stable(q));
endmodule

// File: rtl/sc_plain_store.sv
module sc_plain_store #(
  parameter int                DATA_W    = 32,
  parameter int                NUM_REGS  = 48,
  parameter int                IDX_W     = 6,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_range,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= RESET_VAL;
    end else if (we && in_range) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = in_range ? mem[idx] : '0;

  // R6: written word reads back next cycle at the same index
  a_r6_store_readback: assert property (@(posedge clk) disable iff (rst)
    (we && in_range) ##1 (idx == $past(idx)) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/sc_alias_regbank.sv
module sc_alias_regbank #(
  parameter int ADDR_W   = 8,
  parameter int BUS_W    = 64,
  parameter int NUM_REGS = 48,
  parameter logic [sc_alias_pkg::NCTL-1:0][31:0] CTL_RESET = {
    32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_0000,
    32'h0000_00F0, 32'h8000_0001, 32'h1234_5678},
  parameter logic [31:0] PLAIN_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              err,
  output logic [31:0]       strap0_q,
  output logic [31:0]       strap1_q,
  output logic [31:0]       rstc0_q,
  output logic [31:0]       rstc1_q,
  output logic [31:0]       clkstop0_q,
  output logic [31:0]       clkstop1_q
);
  localparam int DATA_W = sc_alias_pkg::DATA_W;
  localparam int NCTL   = sc_alias_pkg::NCTL;
  localparam int IDX_W  = ADDR_W - 2;

  logic [DATA_W-1:0] wdata;
  assign wdata = wr_data[DATA_W-1:0];
  if (BUS_W > DATA_W) begin : g_wide
    logic unused_hi;
    assign unused_hi = ^wr_data[BUS_W-1:DATA_W];
  end

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [NCTL-1:0]  prim_hit, clr_hit;

  sc_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr(addr), .idx(idx), .in_range(in_range),
    .prim_hit(prim_hit), .clr_hit(clr_hit));

  logic [DATA_W-1:0] ctl_q [NCTL];
  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    sc_ctl_word #(
      .DATA_W(DATA_W),
      .SET_TYPE(sc_alias_pkg::ctl_is_set(k)),
      .RESET_VAL(CTL_RESET[k])
    ) u_word (
      .clk(clk), .rst(rst), .wr_en(wr_en),
      .prim_hit(prim_hit[k]), .clr_hit(clr_hit[k]),
      .wdata(wdata), .q(ctl_q[k]));
  end

  logic              plain_we;
  logic [DATA_W-1:0] plain_rdata;
  assign plain_we = wr_en && in_range && !(|prim_hit) && !(|clr_hit);

  sc_plain_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
                   .RESET_VAL(PLAIN_RESET)) u_store (
    .clk(clk), .rst(rst), .we(plain_we), .idx(idx), .in_range(in_range),
    .wdata(wdata), .rdata(plain_rdata));

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = plain_rdata;
    if (!in_range || (|clr_hit)) rd_next = '0;
    else if (|prim_hit) begin
      rd_next = '0;
      for (int k = 0; k < NCTL; k++)
        if (prim_hit[k]) rd_next = rd_next | ctl_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      err     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      err <= (wr_en || rd_en) && !in_range;
    end
  end

  assign strap0_q   = ctl_q[0];
  assign strap1_q   = ctl_q[1];
  assign rstc0_q    = ctl_q[2];
  assign rstc1_q    = ctl_q[3];
  assign clkstop0_q = ctl_q[4];
  assign clkstop1_q = ctl_q[5];

  // R8: err only follows an out-of-range access
  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(wr_en || rd_en) && (int'($past(addr) >> 2) >= NUM_REGS)));
  // R4: a read of a clear alias yields zero
  a_r4_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (|clr_hit)) |=> (rd_data == '0));
  // R10: rd_data holds while no read
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sc_alias_regbank_tb.sv
`timescale 1ns/1ps
module sc_alias_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data, strap0_q, strap1_q, rstc0_q, rstc1_q, clkstop0_q, clkstop1_q;
  logic        err;

  int vectors = 0;
  int miscompares = 0;
  bit started = 0;

  always #2 clk = ~clk;

  sc_alias_regbank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .err(err),
    .strap0_q(strap0_q), .strap1_q(strap1_q), .rstc0_q(rstc0_q),
    .rstc1_q(rstc1_q), .clkstop0_q(clkstop0_q), .clkstop1_q(clkstop1_q));

  // behavioural reference model
  bit [31:0] m [64];
  bit [31:0] exp_rd;
  bit        exp_err;

  function automatic bit is_alias(int i);
    return (i == 5 || i == 7 || i == 17 || i == 21 || i == 33 || i == 37);
  endfunction
  function automatic bit is_set(int i);
    return (i == 16 || i == 20 || i == 32 || i == 36);
  endfunction

  always @(posedge clk) begin
    int i;
    bit [31:0] d;
    started = 1;
    if (rst) begin
      for (int j = 0; j < 64; j++) m[j] = 32'h0;
      m[4] = 32'h1234_5678; m[6] = 32'h8000_0001;
      m[16] = 32'h0000_00F0; m[20] = 32'h0;
      m[32] = 32'hFFFF_0000; m[36] = 32'h0000_FFFF;
      exp_rd = 0; exp_err = 0;
    end else begin
      i = int'(addr) / 4;
      d = wr_data[31:0];
      exp_err = (wr_en || rd_en) && (i >= 48);
      if (rd_en) exp_rd = (i >= 48 || is_alias(i)) ? 32'h0 : m[i];
      if (wr_en && i < 48) begin
        if (is_alias(i))    m[i-1] = m[i-1] & ~d;
        else if (is_set(i)) m[i]   = m[i] | d;
        else                m[i]   = d;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (started) begin
    chk("R11 strap0", strap0_q, m[4]);
    chk("R11 strap1", strap1_q, m[6]);
    chk("R11 rstc0", rstc0_q, m[16]);
    chk("R11 rstc1", rstc1_q, m[20]);
    chk("R11 clkstop0", clkstop0_q, m[32]);
    chk("R11 clkstop1", clkstop1_q, m[36]);
    chk("R10 rd_data", rd_data, exp_rd);
    chk("R8 err", {31'b0, err}, {31'b0, exp_err});
  end

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #40000;
    miscompares++;
    $display("FAIL watchdog got=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset values
    chk("R9 clkstop0 default", clkstop0_q, 32'hFFFF_0000);
    chk("R9 strap1 default", strap1_q, 32'h8000_0001);
    rd_chk("R9 plain default", 8'h00, 32'h0);
    // R2 set
    wr(8'h80, 64'h0000_00FF);
    chk("R2 clkstop0 or", clkstop0_q, 32'hFFFF_00FF);
    wr(8'h90, 64'h00F0_0000);
    chk("R2 clkstop1 or", clkstop1_q, 32'h00F0_FFFF);
    // R3 clear through alias
    wr(8'h84, 64'hFF00_000F);
    chk("R3 clkstop0 clear", clkstop0_q, 32'h00FF_00F0);
    // R4 alias has no storage
    rd_chk("R4 alias reads zero", 8'h84, 32'h0);
    rd_chk("R4 primary intact", 8'h80, 32'h00FF_00F0);
    rd_chk("R4 word above alias", 8'h88, 32'h0);
    // R12 set then clear restores
    wr(8'h50, 64'hA5);
    chk("R12 rstc1 set", rstc1_q, 32'hA5);
    wr(8'h54, 64'hA5);
    chk("R12 rstc1 restored", rstc1_q, 32'h0);
    // R5 strap overwrite and clear
    wr(8'h10, 64'h1);
    chk("R5 strap0 overwrite", strap0_q, 32'h1);
    wr(8'h1C, 64'h8000_0000);
    chk("R5 strap1 clear", strap1_q, 32'h1);
    // R6 plain storage
    wr(8'h08, 64'hDEAD_BEEF);
    rd_chk("R6 plain readback", 8'h08, 32'hDEAD_BEEF);
    wr(8'h08, 64'h1);
    rd_chk("R6 plain overwrite", 8'h08, 32'h1);
    // R7 truncation
    wr(8'h0C, 64'hFFFF_FFFF_0000_0055);
    rd_chk("R7 low bits only", 8'h0C, 32'h55);
    wr(8'h40, 64'hFFFF_FFFF_0000_0000);
    chk("R7 upper bits no set", rstc0_q, 32'h0000_00F0);
    // R1 unaligned address decodes to word
    wr(8'h22, 64'h77);
    rd_chk("R1 index by shift", 8'h20, 32'h77);
    // R8 out of range
    @(negedge clk); addr = 8'hC0; wr_data = 64'h1234; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk("R8 err pulse", {31'b0, err}, 32'h1);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, err}, 32'h0);
    rd_chk("R8 out-of-range read", 8'hFC, 32'h0);
    rd_chk("R8 write ignored at 0x00", 8'h00, 32'h0);
    // R10 read sees pre-write value
    @(negedge clk); addr = 8'h08; wr_data = 64'h99; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R10 old value read", rd_data, 32'h1);
    rd_chk("R10 new value later", 8'h08, 32'h99);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule